// File: doc/BRIEF.md
# Debug Memory Access Command Parser

This block follows the conversation on a single-wire debug link one level above the bit receiver. The receiver hands it every acknowledged frame as a one-cycle strobe, with the frame's payload byte and its start-bit direction. The parser keeps track of where the conversation stands. A frame can be a command. After a read or write command come a byte count, then a big-endian address of several bytes, then the data bytes themselves. Each data byte goes out as a strobe, with its memory address and with a flag that says whether the host wrote it or the target returned it.

The parser also tells the receiver the length of the next frame. While it waits for a command it raises a select output, and the receiver then expects a short command frame instead of a full byte frame. When the synchronization detector sees a long low pulse, it sends a framing reset, which abandons any transfer in progress. Commands outside the known set raise a one-cycle flag and are otherwise dropped.

Top module: `dbgp_parse`

## Requirements
- R1: After the synchronous reset, `want_cmd` is 1 and `dat_vld`, `unk_cmd`, `cmd_code` and `dat_addr` are 0.
- R2: In the command state, a frame's payload bits [2:0] form the command code: 0 is system reset, 1 is read, 2 is write. `cmd_code` shows this code from the cycle after the frame. The upper payload bits of a command frame are ignored.
- R3: Codes 0 and 3..7 leave the parser in the command state. Codes 3..7 pulse `unk_cmd` for exactly one cycle, and code 0 does not pulse it.
- R4: A read or write command drops `want_cmd` in the cycle after the command frame. The next frame is taken as the byte count.
- R5: The three frames after the count form the 24-bit address, most significant byte first.
- R6: Each data frame gives a one-cycle `dat_vld` in the next cycle. In that cycle `dat_byte` carries the payload and `dat_dir` carries the frame's direction bit (1 = read from target, 0 = written by host).
- R7: `dat_addr` equals the assembled address for the first data byte and rises by one for each later byte. It wraps modulo 2^24.
- R8: After as many data frames as the count gives, `want_cmd` is 1 in the cycle after the last data frame. A count of 0 means one data byte.
- R9: `sync_rst` puts the parser back into the command state in the next cycle. It takes precedence over a frame in the same cycle, and that frame yields no data strobe and no unknown flag.
- R10: In cycles without `frm_vld`, `dat_vld` and `unk_cmd` stay 0, and `cmd_code` and the protocol position do not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_rst | input | 1 | Framing reset from the synchronization detector |
| frm_vld | input | 1 | Acknowledged frame strobe |
| frm_data | input | 8 | Frame payload |
| frm_dir | input | 1 | Frame start-bit direction, 1 = target |
| want_cmd | output | 1 | Next frame is a command frame |
| cmd_code | output | 3 | Last command code received |
| unk_cmd | output | 1 | One-cycle unknown-command flag |
| dat_vld | output | 1 | Data byte strobe |
| dat_byte | output | 8 | Data byte |
| dat_dir | output | 1 | Data byte direction |
| dat_addr | output | 24 | Address of the data byte |

## Verification
A wrong protocol position shows at the ports within one frame. `want_cmd` gives the wrong value in the cycle after the frame, or a data strobe appears or fails to appear one cycle after a data frame. A fault in address assembly or increment shows on `dat_addr` at the very next data strobe. A count that is off by one moves the return of `want_cmd` by one frame. Each of these faults is therefore seen one cycle after the frame that exposes it.

// File: rtl/dbgp_pkg.sv
package dbgp_pkg;
  typedef enum logic [2:0] {
    ST_CMD,
    ST_CNT,
    ST_ADDR,
    ST_DATA
  } pst_t;

  localparam int unsigned CODE_SRST = 0;
  localparam int unsigned CODE_RD   = 1;
  localparam int unsigned CODE_WR   = 2;
endpackage

// File: rtl/dbgp_seq.sv
module dbgp_seq
  import dbgp_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CMD_W  = 3,
  parameter int unsigned ABYTES = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sync_rst,
  input  logic              frm_vld,
  input  logic [DATA_W-1:0] frm_data,
  output logic              want_cmd_q,
  output logic              cmd_stb,
  output logic              addr_stb,
  output logic              data_stb
);
  localparam int unsigned AIDX_W = $clog2(ABYTES + 1);

  pst_t              state_q, state_d;
  logic [DATA_W-1:0] remain_q;
  logic [AIDX_W-1:0] aidx_q;
  logic              take;
  logic [CMD_W-1:0]  code;

  assign take     = frm_vld && !sync_rst;
  assign code     = frm_data[CMD_W-1:0];
  assign cmd_stb  = take && (state_q == ST_CMD);
  assign addr_stb = take && (state_q == ST_ADDR);
  assign data_stb = take && (state_q == ST_DATA);

  always_comb begin
    state_d = state_q;
    if (sync_rst) begin
      state_d = ST_CMD;
    end else if (frm_vld) begin
      case (state_q)
        ST_CMD:  if (code == CMD_W'(CODE_RD) || code == CMD_W'(CODE_WR)) state_d = ST_CNT;
        ST_CNT:  state_d = ST_ADDR;
        ST_ADDR: if (aidx_q == AIDX_W'(ABYTES - 1)) state_d = ST_DATA;
        ST_DATA: if (remain_q == DATA_W'(1)) state_d = ST_CMD;
        default: state_d = ST_CMD;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_CMD;
      remain_q   <= '0;
      aidx_q     <= '0;
      want_cmd_q <= 1'b1;
    end else begin
      state_q    <= state_d;
      want_cmd_q <= (state_d == ST_CMD);
      if (sync_rst) begin
        aidx_q <= '0;
      end else if (frm_vld) begin
        if (state_q == ST_CNT) begin
          remain_q <= (frm_data == '0) ? DATA_W'(1) : frm_data;
          aidx_q   <= '0;
        end
        if (state_q == ST_ADDR) aidx_q <= aidx_q + AIDX_W'(1);
        if (state_q == ST_DATA) remain_q <= remain_q - DATA_W'(1);
      end
    end
  end
endmodule

// File: rtl/dbgp_addr.sv
module dbgp_addr #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_en,
  input  logic              inc_en,
  input  logic [DATA_W-1:0] byte_in,
  output logic [ADDR_W-1:0] ptr_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q <= '0;
    end else if (load_en) begin
      ptr_q <= {ptr_q[ADDR_W-DATA_W-1:0], byte_in};
    end else if (inc_en) begin
      ptr_q <= ptr_q + ADDR_W'(1);
    end
  end
endmodule

// File: rtl/dbgp_out.sv
module dbgp_out
  import dbgp_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned CMD_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_stb,
  input  logic              data_stb,
  input  logic [DATA_W-1:0] frm_data,
  input  logic              frm_dir,
  input  logic [ADDR_W-1:0] ptr,
  output logic [CMD_W-1:0]  cmd_code,
  output logic              unk_cmd,
  output logic              dat_vld,
  output logic [DATA_W-1:0] dat_byte,
  output logic              dat_dir,
  output logic [ADDR_W-1:0] dat_addr
);
  logic [CMD_W-1:0] code;
  assign code = frm_data[CMD_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_code <= '0;
      unk_cmd  <= 1'b0;
      dat_vld  <= 1'b0;
      dat_byte <= '0;
      dat_dir  <= 1'b0;
      dat_addr <= '0;
    end else begin
      unk_cmd <= 1'b0;
      dat_vld <= data_stb;
      if (cmd_stb) begin
        cmd_code <= code;
        unk_cmd  <= (code > CMD_W'(CODE_WR));
      end
      if (data_stb) begin
        dat_byte <= frm_data;
        dat_dir  <= frm_dir;
        dat_addr <= ptr;
      end
    end
  end
endmodule

// File: rtl/dbgp_parse.sv
module dbgp_parse #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned CMD_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sync_rst,
  input  logic              frm_vld,
  input  logic [DATA_W-1:0] frm_data,
  input  logic              frm_dir,
  output logic              want_cmd,
  output logic [CMD_W-1:0]  cmd_code,
  output logic              unk_cmd,
  output logic              dat_vld,
  output logic [DATA_W-1:0] dat_byte,
  output logic              dat_dir,
  output logic [ADDR_W-1:0] dat_addr
);
  localparam int unsigned ABYTES = ADDR_W / DATA_W;

  logic              cmd_stb, addr_stb, data_stb;
  logic [ADDR_W-1:0] ptr;

  dbgp_seq #(.DATA_W(DATA_W), .CMD_W(CMD_W), .ABYTES(ABYTES)) u_seq (
    .clk(clk), .rst(rst), .sync_rst(sync_rst), .frm_vld(frm_vld),
    .frm_data(frm_data), .want_cmd_q(want_cmd), .cmd_stb(cmd_stb),
    .addr_stb(addr_stb), .data_stb(data_stb)
  );

  dbgp_addr #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_addr (
    .clk(clk), .rst(rst), .load_en(addr_stb), .inc_en(data_stb),
    .byte_in(frm_data), .ptr_q(ptr)
  );

  dbgp_out #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CMD_W(CMD_W)) u_out (
    .clk(clk), .rst(rst), .cmd_stb(cmd_stb), .data_stb(data_stb),
    .frm_data(frm_data), .frm_dir(frm_dir), .ptr(ptr),
    .cmd_code(cmd_code), .unk_cmd(unk_cmd), .dat_vld(dat_vld),
    .dat_byte(dat_byte), .dat_dir(dat_dir), .dat_addr(dat_addr)
  );
endmodule

// File: rtl/dbgp_chk.sv
module dbgp_chk #(
  parameter int unsigned CMD_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             sync_rst,
  input logic             frm_vld,
  input logic             want_cmd,
  input logic             unk_cmd,
  input logic             dat_vld,
  input logic [CMD_W-1:0] cmd_code
);
  p_sync_to_cmd_r9: assert property (@(posedge clk) disable iff (rst)
    sync_rst |=> want_cmd);

  p_unk_stays_cmd_r3: assert property (@(posedge clk) disable iff (rst)
    unk_cmd |-> want_cmd);

  p_dat_from_frame_r6: assert property (@(posedge clk) disable iff (rst)
    dat_vld |-> ($past(frm_vld) && !$past(sync_rst)));

  p_dat_not_cmd_r4: assert property (@(posedge clk) disable iff (rst)
    dat_vld |-> !$past(want_cmd));

  p_code_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !frm_vld |=> $stable(cmd_code));

  p_unk_from_frame_r10: assert property (@(posedge clk) disable iff (rst)
    unk_cmd |-> $past(frm_vld));
endmodule

bind dbgp_parse dbgp_chk #(.CMD_W(CMD_W)) u_chk (
  .clk(clk), .rst(rst), .sync_rst(sync_rst), .frm_vld(frm_vld),
  .want_cmd(want_cmd), .unk_cmd(unk_cmd), .dat_vld(dat_vld),
  .cmd_code(cmd_code)
);

// File: tb/test_dbgp_parse.sv
module test_dbgp_parse;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sync_rst = 1'b0;
  logic        frm_vld = 1'b0;
  logic [7:0]  frm_data = '0;
  logic        frm_dir = 1'b0;
  logic        want_cmd, unk_cmd, dat_vld, dat_dir;
  logic [2:0]  cmd_code;
  logic [7:0]  dat_byte;
  logic [23:0] dat_addr;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  dbgp_parse i_dbgp_parse (
    .clk(clk), .rst(rst), .sync_rst(sync_rst), .frm_vld(frm_vld),
    .frm_data(frm_data), .frm_dir(frm_dir), .want_cmd(want_cmd),
    .cmd_code(cmd_code), .unk_cmd(unk_cmd), .dat_vld(dat_vld),
    .dat_byte(dat_byte), .dat_dir(dat_dir), .dat_addr(dat_addr)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Called at a negedge; returns at the next negedge, after the capturing edge.
  task automatic frame(input logic [7:0] d, input logic dir);
    frm_vld  = 1'b1;
    frm_data = d;
    frm_dir  = dir;
    @(negedge clk);
    frm_vld  = 1'b0;
  endtask

  task automatic idle_check();
    @(negedge clk);
    check("R10 idle dat_vld", 32'(dat_vld), 0);
    check("R10 idle unk_cmd", 32'(unk_cmd), 0);
  endtask

  task automatic burst(input logic [2:0] code, input int cnt, input logic [23:0] a, input logic dir);
    int n;
    n = (cnt == 0) ? 1 : cnt;
    frame({5'b10101, code}, 1'b0);
    check("R2 cmd_code", 32'(cmd_code), 32'(code));
    check("R4 want_cmd low", 32'(want_cmd), 0);
    frame(8'(cnt), 1'b0);
    check("R4 count frame", 32'(want_cmd), 0);
    frame(a[23:16], 1'b0);
    frame(a[15:8], 1'b0);
    frame(a[7:0], 1'b0);
    check("R5 no data during address", 32'(dat_vld), 0);
    idle_check();
    for (int i = 0; i < n; i++) begin
      logic [7:0] b;
      b = 8'(a[7:0] ^ 8'(i * 37 + cnt));
      frame(b, dir);
      check("R6 dat_vld", 32'(dat_vld), 1);
      check("R6 dat_byte", 32'(dat_byte), 32'(b));
      check("R6 dat_dir", 32'(dat_dir), 32'(dir));
      check("R7 dat_addr", 32'(dat_addr), 32'(24'(a + 24'(i))));
      check("R8 want_cmd", 32'(want_cmd), (i == n - 1) ? 1 : 0);
      if (i == 0) idle_check();
    end
    idle_check();
  endtask

  initial begin
    #1500000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 want_cmd", 32'(want_cmd), 1);
    check("R1 dat_vld", 32'(dat_vld), 0);
    check("R1 unk_cmd", 32'(unk_cmd), 0);
    check("R1 cmd_code", 32'(cmd_code), 0);
    check("R1 dat_addr", 32'(dat_addr), 0);

    // R3: sweep every command code that is not read or write
    for (int c = 0; c < 8; c++) begin
      if (c == 1 || c == 2) continue;
      frame({5'b11111, 3'(c)}, 1'b0);
      check("R2 cmd_code", 32'(cmd_code), 32'(c));
      check("R3 want_cmd stays", 32'(want_cmd), 1);
      check("R3 unk_cmd pulse", 32'(unk_cmd), (c >= 3) ? 1 : 0);
      idle_check();
      check("R3 still cmd", 32'(want_cmd), 1);
    end

    // R6 R7 R8: counts 0..6, both commands and directions
    for (int cnt = 0; cnt < 7; cnt++) begin
      for (int k = 0; k < 2; k++) begin
        burst(3'(k + 1), cnt, 24'h123456 + 24'(cnt * 4099), 1'(k));
      end
    end
    // R7 address wrap at 2^24
    burst(3'd1, 4, 24'hFFFFFE, 1'b1);
    // R8 large count
    burst(3'd2, 40, 24'h00FF80, 1'b0);

    // R9: sync during address, coincident with a frame
    frame(8'h02, 1'b0);
    frame(8'h03, 1'b0);
    frame(8'hAB, 1'b0);
    sync_rst = 1'b1;
    frame(8'h01, 1'b0);
    sync_rst = 1'b0;
    check("R9 want_cmd", 32'(want_cmd), 1);
    check("R9 no data", 32'(dat_vld), 0);
    check("R9 no unk", 32'(unk_cmd), 0);
    burst(3'd2, 2, 24'h000010, 1'b0);

    // R9: sync during data phase
    frame(8'h01, 1'b0);
    frame(8'h05, 1'b0);
    frame(8'h00, 1'b0);
    frame(8'h00, 1'b0);
    frame(8'h20, 1'b0);
    frame(8'h77, 1'b1);
    check("R6 first byte before sync", 32'(dat_vld), 1);
    sync_rst = 1'b1;
    frame(8'h07, 1'b1);
    sync_rst = 1'b0;
    check("R9 data discarded", 32'(dat_vld), 0);
    check("R9 back to cmd", 32'(want_cmd), 1);
    check("R9 cmd_code unchanged", 32'(cmd_code), 1);
    burst(3'd1, 1, 24'hABCDEF, 1'b1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule